// File: doc/BRIEF.md
# Serial Output Stop Controller

This block lets software stop and restart twelve clock outputs one by one without producing a shortened pulse on any of them. A one-wire serial frame, sampled on a free-running serial clock, loads a twelve-bit enable mask. Each mask bit is carried into the clock domain of the output it controls and is applied only while that output's source clock is low. A stopped output therefore always parks at logic 0, and a restarted output always begins with a full-width high phase.

Two further clocks, the bank C lane 0 clock and the feedback clock, pass straight through and never respond to the mask. The block gates clocks that already exist; it does not generate them and it does not drive pads. The serial line carries no valid/ready handshake and cannot apply back-pressure: a frame is marked by its start bit alone, and its bits arrive one per serial clock period without a pause. The sender must keep to that pace.

Top module: `outstop_ctrl`

## Requirements
- R1: While the receiver is idle, a high data line is not a frame. A low level sampled on a rising serial clock edge is the start bit, and exactly 12 data bits follow it, one bit on each of the next 12 rising edges.
- R2: Data bit k (k = 0..11, counted from the first bit after the start bit) controls `clk_gated[k]`. Lanes 0-3 are bank A outputs 0-3, lanes 4-7 are bank B outputs 0-3, lanes 8-10 are bank C outputs 1-3, and lane 11 is the sync-pulse output.
- R3: A mask bit of 1 lets its lane run. A mask bit of 0 stops the lane, and the stopped lane rests at logic 0.
- R4: A new mask takes effect only after all 12 bits have been sampled. A frame that is only partly received changes no output.
- R5: When the 12th bit has been sampled, the receiver goes back to searching for a start bit at once, so a second frame can begin on the very next serial clock edge.
- R6: An output is enabled or stopped only while its source clock is low. Every high pulse on a gated output lasts the full high phase of its source clock.
- R7: Reset sets all 12 mask bits and all 12 gates to 1, so every lane runs, and puts the receiver in the idle state. Reset has this effect at any time, including after lanes have been stopped.
- R8: `clk_keep0` and `clk_fbk` repeat their source clocks for every mask value.
- R9: Each mask bit reaches its gate through two flip-flops clocked on the falling edge of that lane's source clock. A committed change therefore shows on the output within three falling edges of that lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_clk | input | 1 | Free-running serial clock; data is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low, shared by all domains |
| ser_din | input | 1 | Serial frame data: a start bit of 0, then 12 enable bits |
| clk_src | input | 12 | Ungated source clocks, one for each stoppable lane |
| clk_keep0_src | input | 1 | Source of the bank C lane 0 clock |
| clk_fbk_src | input | 1 | Source of the feedback clock |
| clk_gated | output | 12 | Gated lane clocks |
| clk_keep0 | output | 1 | Bank C lane 0 clock, never gated |
| clk_fbk | output | 1 | Feedback clock, never gated |

## Verification
On every serial clock cycle the assertions check how the receiver steps from hunting to loading, how its bit count advances and how it returns to hunting. They also check that the committed mask changes only on the cycle after the last bit, and that each gate flip-flop changes only while its source clock is low. Which mask bit reaches which lane, the stop and run polarity, and the fact that no output pulse is shortened can only be seen from the bench's scenarios. There the bench counts edges and measures the width of every high pulse on each output, for walking-zero and walking-one masks, for a frame paused before its last bit, for back-to-back frames, and for a reset applied while lanes are stopped.

// File: rtl/outstop_pkg.sv
package outstop_pkg;
  typedef enum logic {
    RX_HUNT = 1'b0,
    RX_LOAD = 1'b1
  } rx_state_e;
endpackage

// File: rtl/outstop_frame_rx.sv
module outstop_frame_rx
  import outstop_pkg::*;
#(
  parameter int N = 12,
  localparam int CW = $clog2(N)
) (
  input  logic          ser_clk,
  input  logic          rst_n,
  input  logic          ser_din,
  output logic [N-1:0]  mask_q,
  output logic          busy_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  rx_state_e       state_q;
  logic [CW-1:0]   cnt_q;
  logic [N-2:0]    shift_q;

  always_ff @(posedge ser_clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_HUNT;
      cnt_q   <= '0;
      shift_q <= '0;
      mask_q  <= '1;
    end else begin
      unique case (state_q)
        RX_HUNT: begin
          if (!ser_din) begin
            state_q <= RX_LOAD;
            cnt_q   <= '0;
          end
        end
        RX_LOAD: begin
          if (cnt_q == LAST) begin
            mask_q  <= {ser_din, shift_q};
            state_q <= RX_HUNT;
            cnt_q   <= '0;
          end else begin
            shift_q <= {ser_din, shift_q[N-2:1]};
            cnt_q   <= cnt_q + CW'(1);
          end
        end
        default: state_q <= RX_HUNT;
      endcase
    end
  end

  assign busy_o = (state_q == RX_LOAD);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/outstop_gate_cell.sv
module outstop_gate_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_src,
  input  logic rst_n,
  input  logic en_async,
  output logic en_o,
  output logic clk_gated
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], en_async};
  end

  assign en_o      = sync_q[SYNC_STAGES-1];
  assign clk_gated = clk_src & en_o;
endmodule

// File: rtl/outstop_ctrl.sv
module outstop_ctrl #(
  parameter int N_GATED = 12
) (
  input  logic               ser_clk,
  input  logic               rst_n,
  input  logic               ser_din,
  input  logic [N_GATED-1:0] clk_src,
  input  logic               clk_keep0_src,
  input  logic               clk_fbk_src,
  output logic [N_GATED-1:0] clk_gated,
  output logic               clk_keep0,
  output logic               clk_fbk
);
  localparam int CW = $clog2(N_GATED);

  logic [N_GATED-1:0] mask_q;
  logic               rx_busy;
  logic [CW-1:0]      rx_cnt;
  logic [N_GATED-1:0] gate_en;

  outstop_frame_rx #(.N(N_GATED)) u_rx (
    .ser_clk (ser_clk),
    .rst_n   (rst_n),
    .ser_din (ser_din),
    .mask_q  (mask_q),
    .busy_o  (rx_busy),
    .cnt_o   (rx_cnt)
  );

  for (genvar g = 0; g < N_GATED; g++) begin : g_lane
    outstop_gate_cell #(.SYNC_STAGES(2)) u_cell (
      .clk_src   (clk_src[g]),
      .rst_n     (rst_n),
      .en_async  (mask_q[g]),
      .en_o      (gate_en[g]),
      .clk_gated (clk_gated[g])
    );
  end

  assign clk_keep0 = clk_keep0_src;
  assign clk_fbk   = clk_fbk_src;
endmodule

// File: rtl/outstop_ctrl_chk.sv
module outstop_ctrl_chk #(
  parameter int N = 12,
  localparam int CW = $clog2(N)
) (
  input logic          ser_clk,
  input logic          rst_n,
  input logic          ser_din,
  input logic          busy,
  input logic [CW-1:0] cnt,
  input logic [N-1:0]  mask,
  input logic [N-1:0]  clk_src,
  input logic [N-1:0]  gate_en
);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  assert_idle_hold_R1: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (!busy && ser_din) |=> !busy);

  assert_start_bit_R1: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (!busy && !ser_din) |=> (busy && cnt == '0));

  assert_count_step_R2: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (busy && cnt != LAST) |=> (busy && cnt == $past(cnt) + CW'(1)));

  assert_last_bit_lane_R2: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (busy && cnt == LAST) |=> (mask[N-1] == $past(ser_din)));

  assert_no_partial_R4: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (mask != $past(mask)) |-> $past(busy && cnt == LAST));

  assert_rehunt_R5: assert property (@(posedge ser_clk) disable iff (!rst_n)
    (busy && cnt == LAST) |=> !busy);

  for (genvar g = 0; g < N; g++) begin : g_glitch
    always @(posedge gate_en[g] or negedge gate_en[g]) begin
      if (rst_n === 1'b1) begin
        assert_gate_low_R6: assert (clk_src[g] === 1'b0)
          else $error("gate %0d changed while source high", g);
      end
    end
  end
endmodule

bind outstop_ctrl outstop_ctrl_chk #(.N(N_GATED)) u_chk (
  .ser_clk (ser_clk),
  .rst_n   (rst_n),
  .ser_din (ser_din),
  .busy    (rx_busy),
  .cnt     (rx_cnt),
  .mask    (mask_q),
  .clk_src (clk_src),
  .gate_en (gate_en)
);

// File: tb/outstop_ctrl_bench.sv
`timescale 1ns/1ps
module outstop_ctrl_bench;
  localparam int N = 12;

  logic         ser_clk = 1'b0;
  logic         ser_run = 1'b1;
  logic         rst_n   = 1'b0;
  logic         ser_din = 1'b1;
  logic [N-1:0] clk_src = '0;
  logic         keep0_src = 1'b0;
  logic         fbk_src   = 1'b0;
  logic [N-1:0] clk_gated;
  logic         clk_keep0, clk_fbk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  outstop_ctrl #(.N_GATED(N)) u_outstop_ctrl (
    .ser_clk       (ser_clk),
    .rst_n         (rst_n),
    .ser_din       (ser_din),
    .clk_src       (clk_src),
    .clk_keep0_src (keep0_src),
    .clk_fbk_src   (fbk_src),
    .clk_gated     (clk_gated),
    .clk_keep0     (clk_keep0),
    .clk_fbk       (clk_fbk)
  );

  // 100 MHz serial clock that the bench may pause while low
  initial forever begin
    #5;
    if (ser_run) ser_clk = ~ser_clk;
  end

  for (genvar g = 0; g < N; g++) begin : g_src
    always #(3 + g) clk_src[g] = ~clk_src[g];
  end
  always #4 keep0_src = ~keep0_src;
  always #6 fbk_src   = ~fbk_src;

  function automatic real half_of(input int i);
    if (i < N) return real'(3 + i);
    else if (i == N) return 4.0;
    else return 6.0;
  endfunction

  // Output monitor: rising-edge counts and high-pulse widths
  logic [N+1:0] outs;
  assign outs = {clk_fbk, clk_keep0, clk_gated};
  logic [N+1:0] prev_v = '0;
  int      edges [N+2] = '{default: 0};
  realtime t_rise[N+2];
  bit      t_ok  [N+2] = '{default: 0};
  int      runts = 0;

  always @(outs) begin
    for (int i = 0; i < N + 2; i++) begin
      if (outs[i] !== prev_v[i]) begin
        if (outs[i] === 1'b1) begin
          edges[i]++;
          t_rise[i] = $realtime;
          t_ok[i]   = (rst_n === 1'b1);
        end else if (outs[i] === 1'b0 && prev_v[i] === 1'b1) begin
          if (t_ok[i] && rst_n === 1'b1) begin
            real w;
            w = $realtime - t_rise[i];
            if (w < half_of(i) - 0.01 || w > half_of(i) + 0.01) begin
              runts++;
              $display("FAIL R6 lane %0d pulse width actual=%0.3f expected=%0.3f",
                       i, w, half_of(i));
            end
          end
          t_ok[i] = 0;
        end
      end
    end
    prev_v = outs;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic observe(output logic [N+1:0] got);
    int snap [N+2];
    for (int i = 0; i < N + 2; i++) snap[i] = edges[i];
    #120;
    for (int i = 0; i < N + 2; i++)
      got[i] = ((edges[i] - snap[i]) > 0) || (outs[i] === 1'b1);
  endtask

  task automatic settle_check(input logic [N-1:0] exp, input string tag);
    logic [N+1:0] got;
    #150;
    observe(got);
    check(got[N-1:0] == exp, tag, int'(got[N-1:0]), int'(exp));
  endtask

  task automatic send_head(input logic [N-1:0] m, input int upto);
    @(negedge ser_clk) ser_din = 1'b0;
    for (int k = 0; k < upto; k++) begin
      @(negedge ser_clk) ser_din = m[k];
    end
  endtask

  task automatic send_frame(input logic [N-1:0] m);
    send_head(m, N);
    @(negedge ser_clk) ser_din = 1'b1;
  endtask

  initial begin
    logic [N+1:0] got;
    #30 rst_n = 1'b1;

    // R7: after reset every lane runs
    observe(got);
    check(got[N-1:0] == '1, "R7 reset state all lanes run", int'(got[N-1:0]), 'hFFF);
    check(got[N+1:N] == 2'b11, "R8 ungated clocks after reset", int'(got[N+1:N]), 3);

    // R2 R3 R9: walking zero and walking one masks
    for (int k = 0; k < N; k++) begin
      logic [N-1:0] m;
      m = ~(12'(1) << k);
      send_frame(m);
      settle_check(m, $sformatf("R2/R3 walking zero lane %0d", k));
    end
    for (int k = 0; k < N; k++) begin
      logic [N-1:0] m;
      m = 12'(1) << k;
      send_frame(m);
      settle_check(m, $sformatf("R2/R3 walking one lane %0d", k));
    end

    // R3 R8: all lanes stopped, ungated clocks still run
    send_frame('0);
    #150;
    observe(got);
    check(got[N-1:0] == '0, "R3 all stopped", int'(got[N-1:0]), 0);
    check(got[N+1:N] == 2'b11, "R8 ungated clocks with mask zero", int'(got[N+1:N]), 3);

    // R1: a long idle-high line loads nothing
    send_frame(12'h5A5);
    settle_check(12'h5A5, "R3 pattern 5A5");
    repeat (40) @(negedge ser_clk);
    settle_check(12'h5A5, "R1 idle high keeps mask");

    // R4: frame paused before its last bit changes nothing
    send_frame('1);
    settle_check('1, "R3 all run");
    send_head('0, N - 1);
    @(negedge ser_clk);
    ser_din = 1'b0;
    ser_run = 1'b0;
    settle_check('1, "R4 partial frame not applied");
    ser_run = 1'b1;
    @(negedge ser_clk) ser_din = 1'b1;
    settle_check('0, "R4 mask applied after last bit");

    // R5: back-to-back frames, second start bit right after the 12th bit
    send_head(12'h0F0, N);
    send_frame(12'hF0F);
    settle_check(12'hF0F, "R5 back-to-back second frame");
    send_frame(12'hA5A);
    settle_check(12'hA5A, "R3 pattern A5A");

    // R7: reset while lanes are stopped
    send_frame('0);
    settle_check('0, "R3 stopped before reset");
    @(negedge ser_clk) rst_n = 1'b0;
    #20 rst_n = 1'b1;
    settle_check('1, "R7 reset re-enables all lanes");
    send_frame(12'h3C3);
    settle_check(12'h3C3, "R7 receiver idle after reset");

    // R6: no shortened pulse seen on any lane
    check(runts == 0, "R6 runt pulse count", runts, 0);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1ms;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule